// File: doc/BRIEF.md
# USART Baud and Clock Generator

This block makes the timing strobes for a serial transceiver. A down-counter runs on the system clock, reloads from a 12-bit divisor and emits a base strobe once every divisor+1 cycles. The receiver's recovery logic takes that base strobe as it is. A postscaler divides it by 16, 8 or 2 to make the transmit strobe. All outputs are single-cycle enables in the system clock domain, not derived clocks.

Three operating modes share one path. In asynchronous mode the postscale is 16, or 8 when double speed is selected. In synchronous mode a direction bit picks the role. As master, the block drives a serial clock level toward the clock pin, and the transmit postscale is 2. As slave, it passes an external clock through a two-flop synchronizer and an edge detector, and each detected edge becomes both the transmit and the receive strobe. A polarity bit selects the edge that counts in slave mode and inverts the driven clock in master mode.

Software writes the divisor high bits first into a staging register. The write to the low byte then loads the full value and restarts the counter.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is asserted, `tx_tick`, `rx_tick`, `clk_oe` and `clk_out` are all 0 when all mode inputs are 0.
- R2: A low-byte write loads the divisor as {staged high bits, `div_lo_data`} and restarts the counter. The first base strobe appears on `rx_tick` exactly divisor+1 cycles after the write edge, and no strobe appears at the write edge itself.
- R3: A high-bits write alone leaves the strobe rate unchanged. The staged value takes effect only with the next low-byte write.
- R4: In asynchronous and master modes, `rx_tick` pulses for one cycle, once every divisor+1 system cycles.
- R5: In asynchronous mode with `double_speed`=0, `tx_tick` pulses on every 16th base strobe.
- R6: In asynchronous mode with `double_speed`=1, `tx_tick` pulses on every 8th base strobe.
- R7: In master mode (`sync_sel`=1, `pin_dir_out`=1), `tx_tick` pulses on every 2nd base strobe whatever `double_speed` is. Every `tx_tick` coincides with an `rx_tick`.
- R8: The postscaler clears on a low-byte write and on any change of {`sync_sel`, `double_speed`, `pin_dir_out`}. The first `tx_tick` afterwards comes after the full 16, 8 or 2 base strobes, counted from the clearing edge.
- R9: In master mode, `clk_oe`=1 and `clk_out` starts at the level of `clk_pol` after a clear, then toggles with every base strobe. `clk_pol`=1 therefore gives an idle-high clock. Outside master mode, `clk_oe`=0 and `clk_out` equals `clk_pol`.
- R10: In slave mode (`sync_sel`=1, `pin_dir_out`=0), a rising edge of `ext_clk_in` when `clk_pol`=0, or a falling edge when `clk_pol`=1, gives a one-cycle pulse on both `tx_tick` and `rx_tick`. The pulse is seen in the third cycle after the input changes, counting from the first sampling edge. The other edge direction gives nothing.
- R11: Asynchronous mode ignores `ext_clk_in`. Slave mode ignores the divider, so it produces no strobe while `ext_clk_in` is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_lo_wr | input | 1 | Low-byte write strobe; loads divisor and restarts counter |
| div_lo_data | input | 8 | Divisor low byte |
| div_hi_wr | input | 1 | High-bits write strobe into the staging register |
| div_hi_data | input | DIV_W-8 (4) | Divisor high bits |
| sync_sel | input | 1 | 0 asynchronous, 1 synchronous |
| double_speed | input | 1 | Asynchronous postscale 8 instead of 16 |
| pin_dir_out | input | 1 | Synchronous role: 1 master, 0 slave |
| clk_pol | input | 1 | Edge / idle level select for the serial clock |
| ext_clk_in | input | 1 | External serial clock, asynchronous to `clk` |
| tx_tick | output | 1 | Transmit clock enable |
| rx_tick | output | 1 | Receive base clock enable |
| clk_out | output | 1 | Serial clock level toward the pin |
| clk_oe | output | 1 | Drive enable for the serial clock pin |

## Verification
The toggle check on `clk_out` assumes `clk_pol` does not move in the same cycle as a base strobe. The edge-spacing check assumes polarity stays still between two adjacent cycles. The postscaler range check assumes the mode inputs held steady for the cycle in question. The stimulus changes mode and polarity only at idle points, usually together with a low-byte write that suppresses the strobe. It changes double speed on its own only on a cycle known to carry no base strobe. It toggles `ext_clk_in` no faster than every four cycles, and keeps it steady for several cycles before entering slave mode, so the synchronizer holds no stale edge.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

   typedef enum logic [1:0] {
      CG_ASYNC  = 2'd0,
      CG_MASTER = 2'd1,
      CG_SLAVE  = 2'd2
   } cg_mode_e;

   function automatic cg_mode_e cg_decode(input logic sync_sel, input logic dir_out);
      if (!sync_sel)   return CG_ASYNC;
      else if (dir_out) return CG_MASTER;
      else             return CG_SLAVE;
   endfunction

endpackage

// File: rtl/usart_baud_div.sv
module usart_baud_div #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_wr,
   input  logic [7:0]       lo_data,
   input  logic             hi_wr,
   input  logic [DIV_W-9:0] hi_data,
   output logic             base_tick
);
   localparam int HI_W = DIV_W - 8;

   logic [HI_W-1:0]  hi_stage;
   logic [DIV_W-1:0] divisor;
   logic [DIV_W-1:0] cnt;

   initial begin
      assert (DIV_W >= 9 && DIV_W <= 16) else $error("usart_baud_div: DIV_W out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_stage <= '0;
         divisor  <= '0;
         cnt      <= '0;
      end else begin
         if (hi_wr)
            hi_stage <= hi_data;
         if (lo_wr) begin
            divisor <= {hi_stage, lo_data};
            cnt     <= {hi_stage, lo_data};
         end else if (cnt == '0) begin
            cnt <= divisor;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // a write restarts the count, so no strobe in that cycle
   assign base_tick = (cnt == '0) && !lo_wr;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= divisor); // R4
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R4
   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr |=> cnt == divisor); // R2
   AST_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_wr |=> divisor == $past(divisor)); // R3

endmodule

// File: rtl/usart_tx_postscale.sv
module usart_tx_postscale #(
   parameter int RATIO_ASYNC  = 16,
   parameter int RATIO_DOUBLE = 8,
   parameter int RATIO_SYNC   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_tick,
   input  logic restart,
   input  logic sync_sel,
   input  logic double_speed,
   input  logic pin_dir_out,
   output logic tx_fire,
   output logic ps_clr
);
   localparam int RMAX_AD = (RATIO_ASYNC > RATIO_DOUBLE) ? RATIO_ASYNC : RATIO_DOUBLE;
   localparam int RMAX    = (RMAX_AD > RATIO_SYNC) ? RMAX_AD : RATIO_SYNC;
   localparam int PS_W    = (RMAX > 2) ? $clog2(RMAX) : 1;
   localparam logic [PS_W-1:0] LIM_ASYNC  = PS_W'(RATIO_ASYNC - 1);
   localparam logic [PS_W-1:0] LIM_DOUBLE = PS_W'(RATIO_DOUBLE - 1);
   localparam logic [PS_W-1:0] LIM_SYNC   = PS_W'(RATIO_SYNC - 1);

   logic [PS_W-1:0] ps;
   logic [PS_W-1:0] lim;
   logic [2:0]      key, key_q;
   logic            cfg_chg;

   initial begin
      assert (RATIO_ASYNC >= 2 && RATIO_DOUBLE >= 2 && RATIO_SYNC >= 2)
         else $error("usart_tx_postscale: ratios must be at least 2");
   end

   assign key     = {sync_sel, double_speed, pin_dir_out};
   assign cfg_chg = (key != key_q);
   assign ps_clr  = restart || cfg_chg;

   always_comb begin
      if (sync_sel)          lim = LIM_SYNC;
      else if (double_speed) lim = LIM_DOUBLE;
      else                   lim = LIM_ASYNC;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps    <= '0;
         key_q <= '0;
      end else begin
         key_q <= key;
         if (ps_clr)
            ps <= '0;
         else if (base_tick)
            ps <= (ps == lim) ? '0 : ps + 1'b1;
      end
   end

   assign tx_fire = base_tick && !ps_clr && (ps == lim);

   AST_PS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_chg |-> ps <= lim); // R5
   AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ps_clr |=> ps == '0); // R8

endmodule

// File: rtl/usart_ext_edge.sv
module usart_ext_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic fall_sel,
   output logic edge_hit
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              settled;

   initial begin
      assert (STAGES >= 2) else $error("usart_ext_edge: at least two synchronizer stages");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign settled  = sync_q[STAGES-1];
   // rising when fall_sel=0, falling when fall_sel=1
   assign edge_hit = (settled ^ last_q) && (settled ^ fall_sel);

   AST_EDGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> (!edge_hit || fall_sel != $past(fall_sel))); // R10

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
   import usart_clkgen_pkg::*;
#(
   parameter int DIV_W        = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int RATIO_ASYNC  = 16,
   parameter int RATIO_DOUBLE = 8,
   parameter int RATIO_SYNC   = 2,
   parameter bit TICK_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_lo_wr,
   input  logic [7:0]       div_lo_data,
   input  logic             div_hi_wr,
   input  logic [DIV_W-9:0] div_hi_data,
   input  logic             sync_sel,
   input  logic             double_speed,
   input  logic             pin_dir_out,
   input  logic             clk_pol,
   input  logic             ext_clk_in,
   output logic             tx_tick,
   output logic             rx_tick,
   output logic             clk_out,
   output logic             clk_oe
);
   cg_mode_e mode;
   logic     base_tick, tx_fire, ps_clr, edge_hit;
   logic     tx_next, rx_next, lvl_q;

   assign mode = cg_decode(sync_sel, pin_dir_out);

   usart_baud_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo_wr    (div_lo_wr),
      .lo_data  (div_lo_data),
      .hi_wr    (div_hi_wr),
      .hi_data  (div_hi_data),
      .base_tick(base_tick)
   );

   usart_tx_postscale #(
      .RATIO_ASYNC (RATIO_ASYNC),
      .RATIO_DOUBLE(RATIO_DOUBLE),
      .RATIO_SYNC  (RATIO_SYNC)
   ) u_ps (
      .clk         (clk),
      .rst_n       (rst_n),
      .base_tick   (base_tick),
      .restart     (div_lo_wr),
      .sync_sel    (sync_sel),
      .double_speed(double_speed),
      .pin_dir_out (pin_dir_out),
      .tx_fire     (tx_fire),
      .ps_clr      (ps_clr)
   );

   usart_ext_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (ext_clk_in),
      .fall_sel(clk_pol),
      .edge_hit(edge_hit)
   );

   // slave uses the external edge, other modes the internal divider
   assign tx_next = (mode == CG_SLAVE) ? edge_hit : tx_fire;
   assign rx_next = (mode == CG_SLAVE) ? edge_hit : base_tick;

   // master clock level: half period is one base strobe
   always_ff @(posedge clk) begin
      if (!rst_n)         lvl_q <= 1'b0;
      else if (ps_clr)    lvl_q <= 1'b0;
      else if (base_tick) lvl_q <= ~lvl_q;
   end

   assign clk_oe  = (mode == CG_MASTER);
   assign clk_out = clk_oe ? (lvl_q ^ clk_pol) : clk_pol;

   generate
      if (TICK_REG) begin : g_tick_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tx_tick <= 1'b0;
               rx_tick <= 1'b0;
            end else begin
               tx_tick <= tx_next;
               rx_tick <= rx_next;
            end
         end

         AST_MASTER_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_tick && clk_oe && $past(clk_oe) && $stable(clk_pol) && !$past(ps_clr))
               |-> clk_out != $past(clk_out)); // R9
      end else begin : g_tick_comb
         assign tx_tick = tx_next && rst_n;
         assign rx_tick = rx_next && rst_n;
      end
   endgenerate

   AST_TX_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |-> rx_tick); // R7

endmodule

// File: tb/usart_clkgen_test.sv
module usart_clkgen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_lo_wr = 1'b0, div_hi_wr = 1'b0;
   logic [7:0] div_lo_data = '0;
   logic [3:0] div_hi_data = '0;
   logic       sync_sel = 1'b0, double_speed = 1'b0, pin_dir_out = 1'b0;
   logic       clk_pol = 1'b0, ext_clk_in = 1'b0;
   logic       tx_tick, rx_tick, clk_out, clk_oe;

   always #4 clk = ~clk;

   usart_clkgen uut (
      .clk(clk), .rst_n(rst_n),
      .div_lo_wr(div_lo_wr), .div_lo_data(div_lo_data),
      .div_hi_wr(div_hi_wr), .div_hi_data(div_hi_data),
      .sync_sel(sync_sel), .double_speed(double_speed), .pin_dir_out(pin_dir_out),
      .clk_pol(clk_pol), .ext_clk_in(ext_clk_in),
      .tx_tick(tx_tick), .rx_tick(rx_tick), .clk_out(clk_out), .clk_oe(clk_oe)
   );

   int    cyc = 0;
   int    n_chk = 0, n_fail = 0;
   int    q_tx[$], q_rx[$];
   bit    mon_en = 1'b0;
   string cur_req = "R1";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s (cycle %0d): actual=%0d expected=%0d", req, what, cyc, act, exp);
      end
   endtask

   // monitor: pops expected strobe cycles and compares with what appears
   always @(negedge clk) begin
      if (mon_en) begin
         while (q_tx.size() > 0 && q_tx[0] < cyc) begin
            check(1'b0, cur_req, "tx_tick missing at expected cycle", 0, q_tx[0]);
            void'(q_tx.pop_front());
         end
         while (q_rx.size() > 0 && q_rx[0] < cyc) begin
            check(1'b0, cur_req, "rx_tick missing at expected cycle", 0, q_rx[0]);
            void'(q_rx.pop_front());
         end
         if (tx_tick) begin
            if (q_tx.size() > 0 && q_tx[0] == cyc) begin
               check(1'b1, cur_req, "tx_tick", 1, 1);
               void'(q_tx.pop_front());
            end else check(1'b0, cur_req, "unexpected tx_tick", 1, 0);
         end
         if (rx_tick) begin
            if (q_rx.size() > 0 && q_rx[0] == cyc) begin
               check(1'b1, cur_req, "rx_tick", 1, 1);
               void'(q_rx.pop_front());
            end else check(1'b0, cur_req, "unexpected rx_tick", 1, 0);
         end
      end
   end

   // called at a negedge; write edge is the next posedge, returns its cycle
   task automatic cfg_write(input logic s, input logic d, input logic o, input logic p,
                            input logic [7:0] lo, output int w);
      sync_sel = s; double_speed = d; pin_dir_out = o; clk_pol = p;
      div_lo_wr = 1'b1; div_lo_data = lo;
      @(negedge clk);
      div_lo_wr = 1'b0;
      w = cyc;
   endtask

   task automatic hi_write(input logic [3:0] v);
      div_hi_wr = 1'b1; div_hi_data = v;
      @(negedge clk);
      div_hi_wr = 1'b0;
   endtask

   // driver: expected base strobes every period, transmit every ratio-th
   task automatic push_ticks(input int w, input int period, input int ratio, input int len);
      for (int k = 1; k * period <= len; k++) begin
         q_rx.push_back(w + k * period);
         if (k % ratio == 0) q_tx.push_back(w + k * period);
      end
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic master_phase(input logic d, input logic p);
      int w;
      cfg_write(1'b1, d, 1'b1, p, 8'd3, w);
      push_ticks(w, 4, 2, 40);
      check(clk_oe == 1'b1, "R9", "clk_oe in master", clk_oe, 1);
      wait_until(w + 2);
      check(clk_out == p, "R9", "clk_out idle level", clk_out, p);
      wait_until(w + 5);
      check(clk_out == !p, "R9", "clk_out after 1st strobe", clk_out, !p);
      wait_until(w + 9);
      check(clk_out == p, "R9", "clk_out after 2nd strobe", clk_out, p);
      wait_until(w + 13);
      check(clk_out == !p, "R9", "clk_out after 3rd strobe", clk_out, !p);
      wait_until(w + 40);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, cur_req, "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int w, w2;
      repeat (4) @(negedge clk);
      // R1: reset state
      check(tx_tick == 1'b0, "R1", "tx_tick in reset", tx_tick, 0);
      check(rx_tick == 1'b0, "R1", "rx_tick in reset", rx_tick, 0);
      check(clk_oe == 1'b0, "R1", "clk_oe in reset", clk_oe, 0);
      check(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 R5 R11: async normal, divisor 2, external clock wiggling
      cur_req = "R4 R5 R11";
      cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 8'd2, w);
      push_ticks(w, 3, 16, 150);
      mon_en = 1'b1;
      check(clk_oe == 1'b0 && clk_out == 1'b0, "R9", "pin idle outside master", clk_oe, 0);
      for (int i = 0; i < 20; i++) begin
         repeat (5) @(negedge clk);
         ext_clk_in = ~ext_clk_in;
      end
      wait_until(w + 150);

      // R6: double speed, divisor 1
      cur_req = "R6";
      cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 8'd1, w);
      push_ticks(w, 2, 8, 70);
      wait_until(w + 70);

      // R8: rewrite of low byte restarts the postscaler
      cur_req = "R8";
      cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 8'd4, w);
      push_ticks(w, 5, 8, 23);
      wait_until(w + 23);
      cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 8'd4, w2);
      push_ticks(w2, 5, 8, 45);
      wait_until(w2 + 45);

      // R8: mode change alone clears the postscaler (change on a strobe-free edge)
      cfg_write(1'b0, 1'b1, 1'b0, 1'b0, 8'd1, w);
      push_ticks(w, 2, 8, 20);
      wait_until(w + 20);
      double_speed = 1'b0;
      for (int t = w + 22; t <= w + 60; t += 2) q_rx.push_back(t);
      q_tx.push_back(w + 52);
      wait_until(w + 60);

      // R2 R3: staged high bits take effect only with the low byte
      cur_req = "R2 R3";
      cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 8'd5, w);
      push_ticks(w, 6, 16, 100);
      wait_until(w + 10);
      hi_write(4'd1);
      wait_until(w + 100);
      cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 8'd2, w);
      push_ticks(w, 259, 16, 600);
      wait_until(w + 300);
      hi_write(4'd0);
      wait_until(w + 600);

      // R7 R9: master, both polarities; double speed ignored in sync mode
      cur_req = "R7 R9";
      master_phase(1'b0, 1'b0);
      master_phase(1'b1, 1'b1);

      // R10 R11: slave, rising edges, divider at 0 ignored
      cur_req = "R10 R11";
      cfg_write(1'b1, 1'b0, 1'b0, 1'b0, 8'd0, w);
      check(clk_oe == 1'b0, "R10", "clk_oe in slave", clk_oe, 0);
      check(clk_out == 1'b0, "R9", "clk_out follows polarity outside master", clk_out, 0);
      repeat (20) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (4) @(negedge clk);
         ext_clk_in = ~ext_clk_in;
         if (ext_clk_in) begin
            q_tx.push_back(cyc + 3);
            q_rx.push_back(cyc + 3);
         end
      end
      repeat (10) @(negedge clk);
      // R10: falling edges with polarity 1
      clk_pol = 1'b1;
      repeat (2) @(negedge clk);
      check(clk_out == 1'b1, "R9", "clk_out follows polarity outside master", clk_out, 1);
      for (int i = 0; i < 8; i++) begin
         repeat (4) @(negedge clk);
         ext_clk_in = ~ext_clk_in;
         if (!ext_clk_in) begin
            q_tx.push_back(cyc + 3);
            q_rx.push_back(cyc + 3);
         end
      end
      repeat (20) @(negedge clk);

      check(q_tx.size() == 0, cur_req, "tx items left in scoreboard", q_tx.size(), 0);
      check(q_rx.size() == 0, cur_req, "rx items left in scoreboard", q_rx.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule